// File: doc/BRIEF.md
# Dual Predictive Rectifier Gate Sequencer

This block drives the gate enables of the two synchronous rectifiers on the secondary side of a single-ended forward converter. It takes a square-wave sync signal from the secondary winding and a fast internal clock. The sync signal's high interval is the primary switch on-time, and its low interval is the freewheeling time. `gate1` drives the forward rectifier during the high interval. `gate2` drives the freewheeling rectifier during the low interval. Each gate is switched off a programmable number of internal ticks before the sync transition that ends its interval. This keeps either rectifier from still conducting when the winding voltage reverses.

The block cannot see the coming edge, so it predicts it from the previous cycle. For `gate1`, one counter measures the current on-time while a second counter counts down the on-time measured in the previous cycle. The `gate2` channel works the same way but measures the whole period. The two counters of each channel swap roles at every sync rising edge. When a prediction turns out too long, the real sync edge switches the gate off. A single sequencer keeps the two gates from being high together. It also holds both gates off until the block has measured a full on-time and a full period. `sync_in` must already be synchronous to `clk`.

Top module: `fwd_sr_ctrl`

## Requirements
- R1: After reset both gates are low. They stay low until a sync rise, the following fall and the next rise have all been detected; the first gate pulse is possible only after that third edge.
- R2: Rises and falls of `sync_in` are detected on the `clk` edge where the sampled value differs from the value sampled one edge earlier. `gate1` can first go high on the second `clk` edge after the edge that detects the rise, and `gate2` on the second edge after the edge that detects the fall.
- R3: With a steady on-time of H sampled-high edges and a gate1 lead of L1 ticks, `gate1` is high for H − L1 − 3 clock cycles per period.
- R4: With a steady period of P edges, on-time H and a gate2 lead of L2 ticks, `gate2` is high for P − H − 3 − L2 cycles. In general the prediction uses the previous period: when the period grows, `gate2` simply goes low early.
- R5: A 2-bit lead select with value c gives a lead of 2·(c+1) ticks (0→2, 1→4, 2→6, 3→8). `lead1_sel` applies to `gate1` only and `lead2_sel` to `gate2` only.
- R6: When the on-time shrinks below its prediction, `gate1` goes low on the edge that detects the sync fall.
- R7: When the period shrinks below its prediction, `gate2` goes low on the edge that detects the sync rise.
- R8: When the on-time just measured is at least the previous period, `gate2` stays low for the whole following low interval.
- R9: While `inhibit2` is sampled high, `gate2` is low after that edge. `gate1` is unaffected.
- R10: `gate1` and `gate2` are never high together. Each gate can go high only if the other gate was low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Sync square wave from the secondary, already synchronous to clk |
| lead1_sel | input | 2 | Lead select for gate1 turn-off |
| lead2_sel | input | 2 | Lead select for gate2 turn-off |
| inhibit2 | input | 1 | High forces gate2 low |
| gate1 | output | 1 | Forward rectifier gate enable |
| gate2 | output | 1 | Freewheeling rectifier gate enable |

## Verification
The hardest cases to reach are the cycles where the prediction and the real waveform disagree. In those cycles the sync edge, not the counters, ends the gate: an on-time shorter than the last one, a period shorter or longer than the last one, and an on-time that swallows the whole previous period. The stimulus reaches them by setting up several identical periods so that each predictor holds a known value, then changing the on-time or period for a single cycle. The bench then checks the gate's pulse length and the index of its last high cycle against values worked out from the previous cycle's measurements. The lead selects and the inhibit are changed only between periods, so that each cycle has a single expected pulse length.

// File: rtl/fwd_sr_pkg.sv
package fwd_sr_pkg;

    // Default counter widths: on-time range and full period range.
    localparam int unsigned DEF_ON_W    = 10;
    localparam int unsigned DEF_PER_W   = 12;
    // Width of a lead (anticipation) amount in ticks.
    localparam int unsigned LEAD_W      = 4;
    // Ticks between a detected sync edge and the earliest gate turn-on.
    localparam int unsigned TURN_ON_DLY = 2;
    // Width of the low-interval blanking counter.
    localparam int unsigned LOW_W       = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,        // no sync rise seen yet
        SQ_LEARN_ON,    // measuring the first on-time
        SQ_LEARN_PER,   // waiting for the rise that closes the first period
        SQ_RUN_HIGH,    // armed, sync high interval
        SQ_RUN_LOW      // armed, sync low interval
    } seq_state_t;

    typedef struct packed {
        logic level;    // sampled sync value
        logic rise;     // rise detected this edge
        logic fall;     // fall detected this edge
    } sync_evt_t;

    // Lead in ticks for a 2-bit select: 2, 4, 6 or 8.
    function automatic logic [LEAD_W-1:0] lead_ticks(input logic [1:0] code);
        return {1'b0, code, 1'b0} + 4'd2;
    endfunction

endpackage

// File: rtl/fwd_sr_edge.sv
module fwd_sr_edge
    import fwd_sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_in,
    output sync_evt_t evt
);

    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_in;
        end
    end

    always_comb begin
        evt.level = sync_in;
        evt.rise  = sync_in & ~sync_q;
        evt.fall  = ~sync_in & sync_q;
    end

endmodule

// File: rtl/fwd_sr_pair.sv
// Two counters that trade roles at each start pulse: one counts the
// current interval up, the other counts the previous interval down.
module fwd_sr_pair #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         grow,
    output logic [W-1:0] meas_q,
    output logic [W-1:0] meas_nx,
    output logic [W-1:0] pred_nx
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q  [2];
    logic [W-1:0] cnt_nx [2];
    logic         sel_q;
    logic         sel_nx;

    always_comb begin
        sel_nx = start ? ~sel_q : sel_q;
        for (int g = 0; g < 2; g++) begin
            if ((g == 1) == sel_q) begin
                // measuring now; on start it hands its count over as a prediction
                if (start) begin
                    cnt_nx[g] = (cnt_q[g] == '0) ? '0 : cnt_q[g] - ONE;
                end else if (grow && (cnt_q[g] != '1)) begin
                    cnt_nx[g] = cnt_q[g] + ONE;
                end else begin
                    cnt_nx[g] = cnt_q[g];
                end
            end else begin
                // predicting now; on start it begins a fresh measurement
                if (start) begin
                    cnt_nx[g] = ONE;
                end else begin
                    cnt_nx[g] = (cnt_q[g] == '0) ? '0 : cnt_q[g] - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            for (int g = 0; g < 2; g++) begin
                cnt_q[g] <= '0;
            end
        end else begin
            sel_q <= sel_nx;
            for (int g = 0; g < 2; g++) begin
                cnt_q[g] <= cnt_nx[g];
            end
        end
    end

    assign meas_q  = cnt_q[sel_q];
    assign meas_nx = cnt_nx[sel_nx];
    assign pred_nx = cnt_nx[~sel_nx];

endmodule

// File: rtl/fwd_sr_seq.sv
module fwd_sr_seq
    import fwd_sr_pkg::*;
#(
    parameter int unsigned ON_W  = DEF_ON_W,
    parameter int unsigned PER_W = DEF_PER_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_evt_t         evt,
    input  logic [ON_W-1:0]   on_meas_q,
    input  logic [ON_W-1:0]   on_meas_nx,
    input  logic [ON_W-1:0]   on_pred_nx,
    input  logic [PER_W-1:0]  per_meas_q,
    input  logic [PER_W-1:0]  per_pred_nx,
    input  logic [LEAD_W-1:0] lead1,
    input  logic [LEAD_W-1:0] lead2,
    input  logic              inhibit2,
    output logic              gate1,
    output logic              gate2
);

    localparam logic [ON_W-1:0]  ON_DLY  = ON_W'(TURN_ON_DLY);
    localparam logic [LOW_W-1:0] LOW_DLY = LOW_W'(TURN_ON_DLY);

    seq_state_t        st_q, st_nx;
    logic [LOW_W-1:0]  lo_q, lo_nx;
    logic [PER_W-1:0]  per_lat_q;
    logic              kill2_q;
    logic              armed;
    logic              g1_nx, g2_nx;
    logic              g1_room, g2_room;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SQ_IDLE:      if (evt.rise) st_nx = SQ_LEARN_ON;
            SQ_LEARN_ON:  if (evt.fall) st_nx = SQ_LEARN_PER;
            SQ_LEARN_PER: if (evt.rise) st_nx = SQ_RUN_HIGH;
            SQ_RUN_HIGH:  if (evt.fall) st_nx = SQ_RUN_LOW;
            SQ_RUN_LOW:   if (evt.rise) st_nx = SQ_RUN_HIGH;
            default:      st_nx = SQ_IDLE;
        endcase
    end

    assign armed = (st_q == SQ_RUN_HIGH) || (st_q == SQ_RUN_LOW);

    always_comb begin
        if (evt.fall) begin
            lo_nx = '0;
        end else if (!evt.level && (lo_q != '1)) begin
            lo_nx = lo_q + LOW_W'(1);
        end else begin
            lo_nx = lo_q;
        end
    end

    // remaining predicted ticks must exceed the lead
    assign g1_room = on_pred_nx > ON_W'(lead1);
    assign g2_room = per_pred_nx > PER_W'(lead2);

    always_comb begin
        g1_nx = armed && evt.level && (on_meas_nx > ON_DLY) && g1_room && !gate2;
        g2_nx = armed && !evt.level && (lo_nx >= LOW_DLY) && g2_room
                && !kill2_q && !inhibit2 && !gate1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            lo_q      <= '0;
            per_lat_q <= '0;
            kill2_q   <= 1'b0;
            gate1     <= 1'b0;
            gate2     <= 1'b0;
        end else begin
            st_q  <= st_nx;
            lo_q  <= lo_nx;
            gate1 <= g1_nx;
            gate2 <= g2_nx;
            if (evt.rise) begin
                per_lat_q <= per_meas_q;
            end
            if (evt.fall) begin
                kill2_q <= PER_W'(on_meas_q) >= per_lat_q;
            end
        end
    end

endmodule

// File: rtl/fwd_sr_ctrl.sv
module fwd_sr_ctrl
    import fwd_sr_pkg::*;
#(
    parameter int unsigned ON_W  = DEF_ON_W,
    parameter int unsigned PER_W = DEF_PER_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic [1:0] lead1_sel,
    input  logic [1:0] lead2_sel,
    input  logic       inhibit2,
    output logic       gate1,
    output logic       gate2
);

    sync_evt_t         evt;
    logic [ON_W-1:0]   on_meas_q, on_meas_nx, on_pred_nx;
    logic [PER_W-1:0]  per_meas_q, per_meas_nx, per_pred_nx;
    logic [LEAD_W-1:0] lead1, lead2;
    logic              on_grow;

    fwd_sr_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .evt     (evt)
    );

    assign on_grow = evt.level & ~evt.rise;

    fwd_sr_pair #(.W(ON_W)) u_on_pair (
        .clk     (clk),
        .rst     (rst),
        .start   (evt.rise),
        .grow    (on_grow),
        .meas_q  (on_meas_q),
        .meas_nx (on_meas_nx),
        .pred_nx (on_pred_nx)
    );

    fwd_sr_pair #(.W(PER_W)) u_per_pair (
        .clk     (clk),
        .rst     (rst),
        .start   (evt.rise),
        .grow    (1'b1),
        .meas_q  (per_meas_q),
        .meas_nx (per_meas_nx),
        .pred_nx (per_pred_nx)
    );

    assign lead1 = lead_ticks(lead1_sel);
    assign lead2 = lead_ticks(lead2_sel);

    fwd_sr_seq #(.ON_W(ON_W), .PER_W(PER_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .on_meas_q   (on_meas_q),
        .on_meas_nx  (on_meas_nx),
        .on_pred_nx  (on_pred_nx),
        .per_meas_q  (per_meas_q),
        .per_pred_nx (per_pred_nx),
        .lead1       (lead1),
        .lead2       (lead2),
        .inhibit2    (inhibit2),
        .gate1       (gate1),
        .gate2       (gate2)
    );

    logic unused_per;
    assign unused_per = ^per_meas_nx;

endmodule

// File: rtl/fwd_sr_ctrl_chk.sv
module fwd_sr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_in,
    input logic       inhibit2,
    input logic       gate1,
    input logic       gate2
);

    logic       seen_q;
    logic [1:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            edges_q <= 2'd0;
        end else begin
            seen_q <= sync_in;
            if ((sync_in != seen_q) && (edges_q != 2'd3)) begin
                edges_q <= edges_q + 2'd1;
            end
        end
    end

    AST_BLIND_UNTIL_LEARNED: assert property (@(posedge clk) disable iff (rst)
        (edges_q != 2'd3) |-> (!gate1 && !gate2)); // R1

    AST_GATE1_ONSET_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(gate1) |-> ($past(sync_in) && $past(sync_in, 2) && $past(sync_in, 3))); // R2

    AST_GATE2_ONSET_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(gate2) |-> (!$past(sync_in) && !$past(sync_in, 2) && !$past(sync_in, 3))); // R2

    AST_GATE1_OFF_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        !sync_in |=> !gate1); // R6

    AST_GATE2_OFF_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> !gate2); // R7

    AST_INHIBIT_HOLDS_GATE2: assert property (@(posedge clk) disable iff (rst)
        inhibit2 |=> !gate2); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(gate1 && gate2)); // R10

    AST_GATE1_AFTER_GATE2_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(gate1) |-> !$past(gate2)); // R10

    AST_GATE2_AFTER_GATE1_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(gate2) |-> !$past(gate1)); // R10

endmodule

bind fwd_sr_ctrl fwd_sr_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .inhibit2 (inhibit2),
    .gate1    (gate1),
    .gate2    (gate2)
);

// File: tb/fwd_sr_ctrl_bench.sv
`timescale 1ns/1ps
module fwd_sr_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic [1:0] lead1_sel = 2'd0;
    logic [1:0] lead2_sel = 2'd0;
    logic       inhibit2 = 1'b0;
    logic       gate1, gate2;

    int vectors = 0;
    int fails   = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    fwd_sr_ctrl u_fwd_sr_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .lead1_sel (lead1_sel),
        .lead2_sel (lead2_sel),
        .inhibit2  (inhibit2),
        .gate1     (gate1),
        .gate2     (gate2)
    );

    // Behavioural reference: elapsed ticks against last cycle's measurements.
    int m_prev, m_e1, m_e2, m_n1, m_n2, m_k;
    bit m_kill, m_have, m_n1ok, m_n2ok, m_g1, m_g2;

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_e1 = 0; m_e2 = 0; m_n1 = 0; m_n2 = 0; m_k = 0;
            m_kill = 0; m_have = 0; m_n1ok = 0; m_n2ok = 0; m_g1 = 0; m_g2 = 0;
        end else begin
            int s, e1, e2, n2, k, x1, x2;
            bit rise, fall, arm, g1, g2;
            s    = int'(sync_in);
            rise = (s == 1) && (m_prev == 0);
            fall = (s == 0) && (m_prev == 1);
            arm  = m_n1ok && m_n2ok;
            x1   = 2 * (int'(lead1_sel) + 1);
            x2   = 2 * (int'(lead2_sel) + 1);
            n2   = m_n2;
            if (rise) begin
                n2 = m_e2; e1 = 1; e2 = 1;
            end else begin
                e2 = m_e2 + 1;
                e1 = (s == 1) ? m_e1 + 1 : m_e1;
            end
            if (fall) k = 0;
            else if (s == 0) k = (m_k < 3) ? m_k + 1 : 3;
            else k = m_k;
            g1 = arm && (s == 1) && (e1 > 2) && ((m_n1 - e1) > x1) && !m_g2;
            g2 = arm && (s == 0) && (k >= 2) && ((n2 - e2) > x2) && !m_kill
                 && !inhibit2 && !m_g1;
            if (fall) begin
                m_kill = (m_e1 >= m_n2);
                m_n1   = m_e1;
                if (m_have) m_n1ok = 1;
            end
            if (rise) begin
                if (m_have) m_n2ok = 1;
                m_have = 1;
            end
            m_n2 = n2; m_e1 = e1; m_e2 = e2; m_k = k;
            m_g1 = g1; m_g2 = g2; m_prev = s;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if ((gate1 !== m_g1) || (gate2 !== m_g2)) begin
                fails++;
                $display("FAIL %s: gates actual %b%b expected %b%b at %0t",
                         cur_req, gate1, gate2, m_g1, m_g2, $time);
            end
            vectors++;
            if (gate1 && gate2) begin  // R10
                fails++;
                $display("FAIL R10: overlap actual 11 expected not 11 at %0t", $time);
            end
        end
    end

    task automatic check(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int c1, c2, f1, f2, l1, l2;

    task automatic run_period(input int hi, input int per);
        c1 = 0; c2 = 0; f1 = -1; f2 = -1; l1 = -1; l2 = -1;
        for (int i = 0; i < per; i++) begin
            sync_in = (i < hi);
            @(posedge clk);
            @(negedge clk);
            if (gate1) begin c1++; if (f1 < 0) f1 = i; l1 = i; end
            if (gate2) begin c2++; if (f2 < 0) f2 = i; l2 = i; end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(int'(gate1), 0, "R1 gate1 after reset");
        check(int'(gate2), 0, "R1 gate2 after reset");

        cur_req = "R1";
        run_period(16, 40);
        check(c1, 0, "R1 gate1 pulses before learning");
        check(c2, 0, "R1 gate2 pulses before learning");

        cur_req = "R3";
        run_period(16, 40);
        check(f1, 2, "R2 gate1 first high index");
        check(f2, 18, "R2 gate2 first high index");
        check(c1, 11, "R3 gate1 width lead 2");
        check(c2, 19, "R4 gate2 width lead 2");

        cur_req = "R5";
        lead1_sel = 2'd3; lead2_sel = 2'd2;
        run_period(16, 40);
        check(c1, 5, "R5 gate1 width lead 8");
        check(c2, 15, "R5 gate2 width lead 6");
        lead1_sel = 2'd1; lead2_sel = 2'd3;
        run_period(16, 40);
        check(c1, 9, "R5 gate1 width lead 4");
        check(c2, 13, "R5 gate2 width lead 8");
        lead1_sel = 2'd0; lead2_sel = 2'd0;
        cur_req = "R4";
        run_period(16, 40);
        check(c1, 11, "R3 steady gate1 width");
        check(c2, 19, "R4 steady gate2 width");

        cur_req = "R6";
        run_period(8, 40);
        check(c1, 6, "R6 gate1 width on shrink");
        check(l1, 7, "R6 gate1 last high index on shrink");
        run_period(16, 40);
        check(c1, 3, "R3 gate1 after short on-time");
        run_period(16, 40);

        cur_req = "R7";
        run_period(16, 28);
        check(c2, 10, "R7 gate2 width on period shrink");
        check(l2, 27, "R7 gate2 last high index on period shrink");
        cur_req = "R4";
        run_period(16, 60);
        check(c2, 7, "R4 gate2 early off on period growth");
        run_period(16, 40);
        check(c2, 22, "R4 gate2 after long period");

        cur_req = "R8";
        run_period(40, 50);
        check(c2, 0, "R8 gate2 kept low when on-time covers period");
        check(c1, 11, "R8 gate1 normal in long on-time");
        run_period(16, 40);
        check(c1, 14, "R3 gate1 bounded by fall");
        check(c2, 22, "R8 gate2 back after kill");

        cur_req = "R9";
        inhibit2 = 1'b1;
        run_period(16, 40);
        check(c2, 0, "R9 gate2 inhibited");
        check(c1, 11, "R9 gate1 unaffected by inhibit");
        inhibit2 = 1'b0;
        run_period(16, 40);
        check(c2, 19, "R9 gate2 after inhibit release");

        cur_req = "R10";
        run_period(16, 40);
        finish_run();
    end

endmodule